// File: doc/BRIEF.md
# Tiled Surface Address Walker

This block turns a rectangular region of a 2D surface into a stream of byte offsets, one per element, laid out according to one of four memory organisations: plain linear rows, or one of three 4 KiB tile shapes. The three tile shapes differ in their inner order. One uses wide row-major rows. One uses narrow columns of 16-byte units. One uses a nested interleave of 8x8, 4x4 and 2x2 byte blocks. On the tiled layouts, address bit 6 can also be folded with higher bits to model channel swizzling.

A client sets the layout, pitch, region origin and size, slice count, slice step, element size and swizzle enable, and then pulses `start`. The block latches that setup and walks the region: slices outermost, then rows, then elements along a row. It presents each offset on a valid/ready handshake and pulses `done` once the final offset has been taken. A copy engine or a converter that moves data between a linear staging buffer and a tiled surface would sit downstream and consume the stream.

Top module: `tile_addr_walker`

## Requirements
- R1: `layoutSel` codes are 0 = linear, 1 = X-major tiles, 2 = Y-major tiles, 3 = W-major tiles. In linear mode each offset equals y * pitch + x, where x is in bytes and y in rows.
- R2: In X-major mode a tile is 8 rows of 512 bytes. tile = (y/8)*(pitch/512) + x/512, and offset = tile*4096 + (y mod 8)*512 + (x mod 512).
- R3: In Y-major mode a tile is 32 rows of 128 bytes made of 16-byte units counted down columns first. unit = ((x mod 128)/16)*32 + (y mod 32), tile = (y/32)*(pitch/128) + x/128, and offset = tile*4096 + unit*16 + (x mod 16).
- R4: In W-major mode a tile is 64x64 bytes. tile = (y/64)*(pitch/64) + x/64. b8 = ((x/8) mod 8)*8 + (y/8) mod 8. Each of b4, b2 and b1 is 2*(y bit k) + (x bit k), for k = 2, 1 and 0 in that order. offset = tile*4096 + b8*64 + b4*16 + b2*4 + b1.
- R5: With `swizzleEn` high in X-major mode, offset bit 6 is replaced by bit 6 XOR bit 9 XOR bit 10 of the tiled offset. All other bits are unchanged.
- R6: With `swizzleEn` high in Y-major or W-major mode, offset bit 6 is replaced by bit 6 XOR bit 9. In linear mode `swizzleEn` has no effect.
- R7: Elements are emitted slice by slice, row by row within a slice, and left to right within a row. x starts at `originX` and grows by `elemBytes` per element. Each new row adds 1 to y and returns x to `originX`. Slice s starts at y = `originY` + s*`sliceStep`. Exactly width*height*slices offsets are emitted.
- R8: While `outValid` is high and `outReady` is low, `outValid` stays high and `outOffset` holds its value on the next cycle.
- R9: `done` is high for one cycle, in the cycle after the last offset is accepted. At that point `outValid` and `busy` are low.
- R10: A `start` pulse while `busy` is high is ignored, together with any setup inputs that change during the walk. The stream in progress continues unchanged.
- R11: A start with zero width, zero height or zero slices emits no offsets and pulses `done` in the cycle after the start.
- R12: After reset `outValid`, `done` and `busy` are low, and `outValid` stays low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk with the current setup (accepted only when idle) |
| layoutSel | input | 2 | Layout code, see R1 |
| pitch | input | PITCH_W | Surface row pitch in bytes |
| originX | input | COORD_W | Region left edge in bytes |
| originY | input | COORD_W | Region top row of the first slice |
| boxWidth | input | CNT_W | Elements per row |
| boxHeight | input | CNT_W | Rows per slice |
| sliceCount | input | CNT_W | Number of slices |
| sliceStep | input | COORD_W | Row distance between consecutive slice origins |
| elemBytes | input | ELEM_W | Element size in bytes |
| swizzleEn | input | 1 | Enable bit-6 address folding |
| outReady | input | 1 | Consumer accepts the offset |
| outValid | output | 1 | An offset is presented |
| outOffset | output | OFF_W | Byte offset of the current element |
| done | output | 1 | One-cycle pulse after the walk completes |
| busy | output | 1 | A walk is in progress |

## Verification
The assertions assume three things about the setup. For a tiled layout, the pitch is a whole multiple of that layout's tile width. Coordinates and offsets stay inside the configured widths, so no wraparound occurs. Setup inputs only matter in the cycle `start` is taken. The random stimulus respects all three: it draws pitches as multiples of 512 bytes and keeps origins, region sizes and slice steps small enough for offsets to fit in 32 bits. Directed cases place regions across tile edges in both x and y for every layout, with swizzling off and on. Other directed cases change the setup and re-pulse `start` in the middle of a walk, and give zero-sized regions. The consumer's ready signal is randomised so that the output is stalled often.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [1:0] {
    LAY_LINEAR = 2'd0,
    LAY_XMAJ   = 2'd1,
    LAY_YMAJ   = 2'd2,
    LAY_WMAJ   = 2'd3
  } tw_layout_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } tw_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic emit;
    logic stepCol;
    logic stepRow;
    logic stepSlice;
    logic drain;
  } tw_strobe_t;

endpackage

// File: rtl/tw_offset_calc.sv
module tw_offset_calc import tw_pkg::*; #(
  parameter int COORD_W = 16,
  parameter int PITCH_W = 16,
  parameter int OFF_W   = 32
) (
  input  tw_layout_e           layout,
  input  logic [COORD_W-1:0]   x,
  input  logic [COORD_W-1:0]   y,
  input  logic [PITCH_W-1:0]   pitch,
  input  logic                 swizzleEn,
  output logic [OFF_W-1:0]     offset
);

  logic [OFF_W-1:0] xw, yw, pw;
  logic [OFF_W-1:0] offLin, offX, offY, offW;
  logic [OFF_W-1:0] tileX, tileY, tileW, unitY;
  logic [11:0]      inTileW;
  logic [OFF_W-1:0] raw;
  logic             flip;

  always_comb begin
    xw = OFF_W'(x);
    yw = OFF_W'(y);
    pw = OFF_W'(pitch);

    offLin = yw * pw + xw;

    tileX = (yw >> 3) * (pw >> 9) + (xw >> 9);
    offX  = (tileX << 12) | ((yw & OFF_W'(7)) << 9) | (xw & OFF_W'(511));

    tileY = (yw >> 5) * (pw >> 7) + (xw >> 7);
    unitY = (((xw >> 4) & OFF_W'(7)) << 5) | (yw & OFF_W'(31));
    offY  = (tileY << 12) | (unitY << 4) | (xw & OFF_W'(15));

    tileW   = (yw >> 6) * (pw >> 6) + (xw >> 6);
    inTileW = {x[5:3], y[5:3], y[2], x[2], y[1], x[1], y[0], x[0]};
    offW    = (tileW << 12) | OFF_W'(inTileW);

    unique case (layout)
      LAY_XMAJ: begin raw = offX; flip = raw[9] ^ raw[10]; end
      LAY_YMAJ: begin raw = offY; flip = raw[9]; end
      LAY_WMAJ: begin raw = offW; flip = raw[9]; end
      default:  begin raw = offLin; flip = 1'b0; end
    endcase

    offset    = raw;
    offset[6] = raw[6] ^ (swizzleEn & flip);
  end

endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl import tw_pkg::*; #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] boxWidth,
  input  logic [CNT_W-1:0] boxHeight,
  input  logic [CNT_W-1:0] sliceCount,
  input  logic             outValid,
  input  logic             outReady,
  output tw_strobe_t       strobe,
  output logic             busy,
  output logic             done
);

  tw_state_e        state;
  logic [CNT_W-1:0] col, row, slc;
  logic [CNT_W-1:0] wLat, hLat, dLat;
  logic             accept, zeroBox, canLoad;
  logic             lastCol, lastRow, lastSlice;

  always_comb begin
    accept    = (state == ST_IDLE) && start;
    zeroBox   = (boxWidth == '0) || (boxHeight == '0) || (sliceCount == '0);
    canLoad   = !outValid || outReady;
    lastCol   = col == wLat - CNT_W'(1);
    lastRow   = row == hLat - CNT_W'(1);
    lastSlice = slc == dLat - CNT_W'(1);

    strobe.loadCfg   = accept && !zeroBox;
    strobe.emit      = (state == ST_RUN) && canLoad;
    strobe.stepCol   = strobe.emit && !lastCol;
    strobe.stepRow   = strobe.emit && lastCol && !lastRow;
    strobe.stepSlice = strobe.emit && lastCol && lastRow && !lastSlice;
    strobe.drain     = (state == ST_DRAIN) && outValid && outReady;
  end

  assign busy = state != ST_IDLE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      col   <= '0;
      row   <= '0;
      slc   <= '0;
      wLat  <= '0;
      hLat  <= '0;
      dLat  <= '0;
      done  <= 1'b0;
    end else begin
      done <= strobe.drain || (accept && zeroBox);
      unique case (state)
        ST_IDLE: if (strobe.loadCfg) begin
          wLat  <= boxWidth;
          hLat  <= boxHeight;
          dLat  <= sliceCount;
          col   <= '0;
          row   <= '0;
          slc   <= '0;
          state <= ST_RUN;
        end
        ST_RUN: begin
          if (strobe.stepCol) col <= col + CNT_W'(1);
          if (strobe.stepRow) begin
            col <= '0;
            row <= row + CNT_W'(1);
          end
          if (strobe.stepSlice) begin
            col <= '0;
            row <= '0;
            slc <= slc + CNT_W'(1);
          end
          if (strobe.emit && lastCol && lastRow && lastSlice) state <= ST_DRAIN;
        end
        ST_DRAIN: if (strobe.drain) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ZERO_BOX: assert property (@(posedge clk) disable iff (!rstN)
    (accept && zeroBox) |=> (done && !busy)); // R11

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (start && state == ST_RUN) |=> busy); // R10

endmodule

// File: rtl/tw_datapath.sv
module tw_datapath import tw_pkg::*; #(
  parameter int COORD_W = 16,
  parameter int PITCH_W = 16,
  parameter int ELEM_W  = 4,
  parameter int OFF_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  tw_strobe_t         strobe,
  input  tw_layout_e         layoutSel,
  input  logic [PITCH_W-1:0] pitch,
  input  logic [COORD_W-1:0] originX,
  input  logic [COORD_W-1:0] originY,
  input  logic [COORD_W-1:0] sliceStep,
  input  logic [ELEM_W-1:0]  elemBytes,
  input  logic               swizzleEn,
  input  logic               outReady,
  output logic               outValid,
  output logic [OFF_W-1:0]   outOffset
);

  tw_layout_e         layLat;
  logic [PITCH_W-1:0] pitchLat;
  logic [COORD_W-1:0] stepLat;
  logic [ELEM_W-1:0]  elemLat;
  logic               swzLat;
  logic [COORD_W-1:0] curX, curY, rowX, sliceY, nextSliceY;
  logic [OFF_W-1:0]   calcOff;

  tw_offset_calc #(.COORD_W(COORD_W), .PITCH_W(PITCH_W), .OFF_W(OFF_W)) u_calc (
    .layout    (layLat),
    .x         (curX),
    .y         (curY),
    .pitch     (pitchLat),
    .swizzleEn (swzLat),
    .offset    (calcOff)
  );

  assign nextSliceY = sliceY + stepLat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      layLat    <= LAY_LINEAR;
      pitchLat  <= '0;
      stepLat   <= '0;
      elemLat   <= '0;
      swzLat    <= 1'b0;
      curX      <= '0;
      curY      <= '0;
      rowX      <= '0;
      sliceY    <= '0;
      outValid  <= 1'b0;
      outOffset <= '0;
    end else begin
      if (strobe.loadCfg) begin
        layLat   <= layoutSel;
        pitchLat <= pitch;
        stepLat  <= sliceStep;
        elemLat  <= elemBytes;
        swzLat   <= swizzleEn;
        curX     <= originX;
        curY     <= originY;
        rowX     <= originX;
        sliceY   <= originY;
      end
      if (strobe.emit) begin
        outOffset <= calcOff;
        outValid  <= 1'b1;
      end else if (strobe.drain) begin
        outValid  <= 1'b0;
      end
      if (strobe.stepCol) curX <= curX + COORD_W'(elemLat);
      if (strobe.stepRow) begin
        curX <= rowX;
        curY <= curY + COORD_W'(1);
      end
      if (strobe.stepSlice) begin
        curX   <= rowX;
        curY   <= nextSliceY;
        sliceY <= nextSliceY;
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outOffset))); // R8

endmodule

// File: rtl/tile_addr_walker.sv
module tile_addr_walker import tw_pkg::*; #(
  parameter int COORD_W = 16,
  parameter int PITCH_W = 16,
  parameter int CNT_W   = 12,
  parameter int ELEM_W  = 4,
  parameter int OFF_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [1:0]         layoutSel,
  input  logic [PITCH_W-1:0] pitch,
  input  logic [COORD_W-1:0] originX,
  input  logic [COORD_W-1:0] originY,
  input  logic [CNT_W-1:0]   boxWidth,
  input  logic [CNT_W-1:0]   boxHeight,
  input  logic [CNT_W-1:0]   sliceCount,
  input  logic [COORD_W-1:0] sliceStep,
  input  logic [ELEM_W-1:0]  elemBytes,
  input  logic               swizzleEn,
  input  logic               outReady,
  output logic               outValid,
  output logic [OFF_W-1:0]   outOffset,
  output logic               done,
  output logic               busy
);

  tw_strobe_t strobe;

  tw_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .boxWidth   (boxWidth),
    .boxHeight  (boxHeight),
    .sliceCount (sliceCount),
    .outValid   (outValid),
    .outReady   (outReady),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done)
  );

  tw_datapath #(.COORD_W(COORD_W), .PITCH_W(PITCH_W), .ELEM_W(ELEM_W), .OFF_W(OFF_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .layoutSel (tw_layout_e'(layoutSel)),
    .pitch     (pitch),
    .originX   (originX),
    .originY   (originY),
    .sliceStep (sliceStep),
    .elemBytes (elemBytes),
    .swizzleEn (swizzleEn),
    .outReady  (outReady),
    .outValid  (outValid),
    .outOffset (outOffset)
  );

  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!outValid && !busy)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !outValid); // R12

endmodule

// File: tb/tile_addr_walker_bench.sv
module tile_addr_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  layoutSel = '0;
  logic [15:0] pitch = '0, originX = '0, originY = '0, sliceStep = '0;
  logic [11:0] boxWidth = '0, boxHeight = '0, sliceCount = '0;
  logic [3:0]  elemBytes = '0;
  logic        swizzleEn = 1'b0;
  logic        outReady = 1'b0;
  logic        outValid, done, busy;
  logic [31:0] outOffset;

  int errCount = 0;
  int checkCount = 0;
  int cycles = 0;
  int readyPct = 100;
  bit monEn = 1'b0;
  bit doneSeen = 1'b0;
  bit busyAtDone = 1'b0;
  bit validAtDone = 1'b0;
  int gotAtDone = 0;
  int unsigned got[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_addr_walker u_tile_addr_walker (
    .clk(clk), .rstN(rstN), .start(start), .layoutSel(layoutSel), .pitch(pitch),
    .originX(originX), .originY(originY), .boxWidth(boxWidth), .boxHeight(boxHeight),
    .sliceCount(sliceCount), .sliceStep(sliceStep), .elemBytes(elemBytes),
    .swizzleEn(swizzleEn), .outReady(outReady), .outValid(outValid),
    .outOffset(outOffset), .done(done), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checkCount++;
    if (!ok) begin
      errCount++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int unsigned refOff(int lay, int unsigned x, int unsigned y,
                                         int unsigned p, bit swz);
    int unsigned o, tile, unit, b8, b4, b2, b1;
    case (lay)
      1: begin
        tile = (y / 8) * (p / 512) + x / 512;
        o = tile * 4096 + (y % 8) * 512 + x % 512;
        if (swz) o = o ^ ((((o >> 9) ^ (o >> 10)) & 1) << 6);
      end
      2: begin
        tile = (y / 32) * (p / 128) + x / 128;
        unit = ((x % 128) / 16) * 32 + y % 32;
        o = tile * 4096 + unit * 16 + x % 16;
        if (swz) o = o ^ (((o >> 9) & 1) << 6);
      end
      3: begin
        tile = (y / 64) * (p / 64) + x / 64;
        b8 = ((x / 8) % 8) * 8 + (y / 8) % 8;
        b4 = ((y / 4) % 2) * 2 + (x / 4) % 2;
        b2 = ((y / 2) % 2) * 2 + (x / 2) % 2;
        b1 = (y % 2) * 2 + x % 2;
        o = tile * 4096 + b8 * 64 + b4 * 16 + b2 * 4 + b1;
        if (swz) o = o ^ (((o >> 9) & 1) << 6);
      end
      default: o = y * p + x;
    endcase
    return o;
  endfunction

  function automatic string layTag(int lay, bit swz);
    if (swz && lay == 1) return "R5";
    if (swz) return "R6";
    case (lay)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R1";
    endcase
  endfunction

  // consumer model and output monitor
  initial begin
    bit prevStall = 1'b0;
    int unsigned prevOff = 0;
    forever begin
      @(negedge clk);
      cycles++;
      outReady = monEn && (($urandom % 100) < readyPct);
      if (prevStall)
        check(outValid && outOffset == prevOff, "R8", "held offset under stall",
              outOffset, prevOff);
      prevStall = outValid && !outReady;
      prevOff = outOffset;
      if (outValid && outReady) got.push_back(outOffset);
      if (done) begin
        doneSeen = 1'b1;
        busyAtDone = busy;
        validAtDone = outValid;
        gotAtDone = got.size();
      end
    end
  end

  initial begin
    @(negedge clk);
    while (cycles < WATCHDOG) @(negedge clk);
    errCount++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, WATCHDOG);
    $display("Result: errors=%0d of %0d checks", errCount, checkCount + 1);
    $finish;
  end

  task automatic runWalk(int lay, int p, int ox, int oy, int w, int h, int d,
                         int step, int eb, bit swz, int pct, bit midStart);
    int unsigned exp[$];
    string tag;
    int waitCnt;
    for (int s = 0; s < d; s++)
      for (int r = 0; r < h; r++)
        for (int c = 0; c < w; c++)
          exp.push_back(refOff(lay, ox + c * eb, oy + s * step + r, p, swz));
    tag = (w == 0 || h == 0 || d == 0) ? "R11" : layTag(lay, swz);
    @(negedge clk);
    got.delete();
    doneSeen = 1'b0;
    readyPct = pct;
    monEn = 1'b1;
    layoutSel = 2'(lay); pitch = 16'(p); originX = 16'(ox); originY = 16'(oy);
    boxWidth = 12'(w); boxHeight = 12'(h); sliceCount = 12'(d);
    sliceStep = 16'(step); elemBytes = 4'(eb); swizzleEn = swz;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (midStart) begin
      // R10: new setup and a fresh start pulse while busy
      repeat (3) @(negedge clk);
      check(busy, "R10", "busy before mid-walk start", busy, 1);
      layoutSel = 2'((lay + 1) % 4); originX = 16'(ox + 100); boxWidth = 12'(1);
      elemBytes = 4'(1); swizzleEn = !swz;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waitCnt = 0;
    while (!doneSeen && waitCnt < 5000) begin
      @(negedge clk);
      waitCnt++;
    end
    check(doneSeen, "R9", "done observed", doneSeen, 1);
    check(got.size() == exp.size(), midStart ? "R10" : (exp.size() == 0 ? "R11" : "R7"),
          "offset count", got.size(), exp.size());
    check(gotAtDone == exp.size() && !busyAtDone && !validAtDone, "R9",
          "done after last transfer, idle", gotAtDone, exp.size());
    for (int i = 0; i < exp.size() && i < got.size(); i++)
      check(got[i] == exp[i], midStart ? "R10" : tag, "offset in R7 order",
            got[i], exp[i]);
    @(negedge clk);
    check(!done, "R9", "done is a single-cycle pulse", done, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!outValid && !done && !busy, "R12", "reset outputs",
          {outValid, done, busy}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && !busy, "R12", "idle after reset", {outValid, busy}, 0);

    // directed: tile-edge crossings in x and y, swizzle off and on
    for (int sw = 0; sw < 2; sw++) begin
      runWalk(1, 2048, 504, 6, 4, 4, 1, 0, 4, sw[0], 100, 0);
      runWalk(1, 2048, 1530, 13, 6, 5, 2, 8, 2, sw[0], 60, 0);
      runWalk(2, 1024, 112, 30, 6, 4, 2, 32, 4, sw[0], 70, 0);
      runWalk(2, 1024, 250, 60, 4, 6, 1, 0, 2, sw[0], 100, 0);
      runWalk(3, 512, 58, 61, 8, 6, 1, 0, 1, sw[0], 50, 0);
      runWalk(3, 512, 125, 3, 6, 4, 2, 64, 1, sw[0], 100, 0);
      runWalk(0, 1536, 10, 3, 5, 3, 2, 7, 2, sw[0], 80, 0);
    end
    // R10: restart attempt while busy
    runWalk(2, 2048, 96, 20, 6, 4, 2, 5, 4, 1'b1, 30, 1);
    // R11: zero-sized regions
    runWalk(1, 2048, 0, 0, 0, 3, 1, 0, 1, 1'b0, 100, 0);
    runWalk(2, 2048, 0, 0, 3, 0, 1, 0, 1, 1'b0, 100, 0);
    runWalk(3, 2048, 0, 0, 3, 2, 0, 0, 1, 1'b0, 100, 0);

    // constrained random walks
    for (int n = 0; n < 40; n++) begin
      runWalk(int'($urandom % 4), 512 * (1 + int'($urandom % 8)),
              int'($urandom % 600), int'($urandom % 100),
              1 + int'($urandom % 8), 1 + int'($urandom % 6), 1 + int'($urandom % 3),
              int'($urandom % 70), 1 << ($urandom % 3), 1'($urandom),
              30 + int'($urandom % 71), 0);
    end

    monEn = 1'b0;
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errCount, checkCount);
    $finish;
  end

endmodule